// File: doc/BRIEF.md
# Sequential Turn-Signal Tail-Light Controller

This block drives two banks of three tail lamps on a vehicle, one bank on each side. A turn request on one side makes that bank light up progressively from the innermost lamp outward, one more lamp per clock. The pattern then clears and restarts for as long as the request stays present. A hazard request, or left and right turn requests arriving together, lights all six lamps at once. The next cycle clears them, so a held hazard request makes all six lamps flash every other cycle.

The controller is a Moore state machine with eight states. The lamp outputs are decoded from the current state alone. The design is split into three parts: next-state logic, a state register that is the only storage, and an output decoder. Each state lasts exactly one clock. Any slower blink rate comes from the clock that is supplied to the block.

States:
- `ST_OFF`: all lamps dark.
- `ST_LEFT1`, `ST_LEFT2`, `ST_LEFT3`: one, two or three left lamps lit.
- `ST_RIGHT1`, `ST_RIGHT2`, `ST_RIGHT3`: one, two or three right lamps lit.
- `ST_ALL`: all six lamps lit.

Transitions:
- `ST_OFF` goes to `ST_ALL` on hazard or on left and right together. Otherwise it goes to `ST_LEFT1` on left alone, to `ST_RIGHT1` on right alone, and stays in `ST_OFF` with no request.
- `LEFT1` goes to `LEFT2`, then to `LEFT3`, then to `OFF`. The right states advance the same way.
- Any turn state goes to `ST_ALL` on hazard.
- `ST_ALL` always goes to `ST_OFF`.

Top module: `tail_light_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes `ST_OFF`, so after that edge both `left_lamp` and `right_lamp` read 3'b000.
- R2: In `ST_OFF` with no request asserted, the lamps stay 3'b000 on both sides at the next edge.
- R3: From `ST_OFF`, left alone (without right or hazard) produces `left_lamp` = 3'b001, 3'b011, 3'b111 on the next three edges, then 3'b000. `right_lamp` stays 3'b000 throughout. Bit 0 is the innermost lamp and bit 2 the outermost.
- R4: From `ST_OFF`, right alone produces the same 3'b001, 3'b011, 3'b111, 3'b000 sequence on `right_lamp`, with `left_lamp` at 3'b000.
- R5: From `ST_OFF`, hazard, or left and right together, gives 3'b111 on both sides at the next edge.
- R6: Hazard asserted in any turn state gives 3'b111 on both sides at the next edge.
- R7: Once started, a turn sequence advances without further requests. A request for the opposite side has no effect until the sequence has returned to all-off.
- R8: Only one bank is ever partly lit. When both banks are nonzero, both read 3'b111.
- R9: The all-on state is always followed by all-off, whatever the inputs. A held hazard request therefore alternates all-on and all-off on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one state per rising edge |
| rst | input | 1 | Active-high synchronous reset |
| left_req | input | 1 | Left turn request |
| right_req | input | 1 | Right turn request |
| hazard_req | input | 1 | Hazard flash request |
| left_lamp | output | 3 | Left lamps, bit 0 inner, bit 2 outer |
| right_lamp | output | 3 | Right lamps, bit 0 inner, bit 2 outer |

## Verification
Two functions can land on the same edge: a turn sequence stepping forward, and a hazard request taking over. The bench raises hazard at each step of a running left sequence and of a running right sequence. In every case it expects all six lamps on at the next edge rather than the next turn step. It also asserts left and right in the same cycle from all-off, where it expects the all-on state. It injects an opposite-side request during a sequence, where it expects the sequence to continue unchanged. A behavioural model tracks the expected lamp pattern, and the outputs are compared with it on every clock.

// File: rtl/tail_light_pkg.sv
package tail_light_pkg;

    // Lamps in one bank; bit 0 is the innermost lamp.
    localparam int SIDE_LAMPS = 3;
    localparam int STATE_W    = 3;

    typedef logic [SIDE_LAMPS-1:0] bank_t;

    localparam bank_t BANK_OFF = '0;
    localparam bank_t BANK_ON  = '1;

    typedef enum logic [STATE_W-1:0] {
        ST_OFF    = 3'd0,
        ST_LEFT1  = 3'd1,
        ST_LEFT2  = 3'd2,
        ST_LEFT3  = 3'd3,
        ST_RIGHT1 = 3'd4,
        ST_RIGHT2 = 3'd5,
        ST_RIGHT3 = 3'd6,
        ST_ALL    = 3'd7
    } lamp_state_e;

    // Pattern for a bank with n lamps lit from the inside outward.
    function automatic bank_t fill_bank(input int n);
        bank_t b;
        for (int i = 0; i < SIDE_LAMPS; i++) begin
            b[i] = (i < n);
        end
        return b;
    endfunction

endpackage

// File: rtl/tl_next_state.sv
module tl_next_state
    import tail_light_pkg::*;
(
    input  lamp_state_e cur_state,
    input  logic        left_req,
    input  logic        right_req,
    input  logic        hazard_req,
    output lamp_state_e nxt_state
);

    logic all_req;
    assign all_req = hazard_req | (left_req & right_req);

    always_comb begin
        nxt_state = ST_OFF;
        unique case (cur_state)
            ST_OFF: begin
                if (all_req)        nxt_state = ST_ALL;
                else if (left_req)  nxt_state = ST_LEFT1;
                else if (right_req) nxt_state = ST_RIGHT1;
                else                nxt_state = ST_OFF;
            end
            ST_LEFT1:  nxt_state = hazard_req ? ST_ALL : ST_LEFT2;
            ST_LEFT2:  nxt_state = hazard_req ? ST_ALL : ST_LEFT3;
            ST_LEFT3:  nxt_state = hazard_req ? ST_ALL : ST_OFF;
            ST_RIGHT1: nxt_state = hazard_req ? ST_ALL : ST_RIGHT2;
            ST_RIGHT2: nxt_state = hazard_req ? ST_ALL : ST_RIGHT3;
            ST_RIGHT3: nxt_state = hazard_req ? ST_ALL : ST_OFF;
            ST_ALL:    nxt_state = ST_OFF;
            default:   nxt_state = ST_OFF;
        endcase
    end

endmodule

// File: rtl/tl_state_reg.sv
module tl_state_reg
    import tail_light_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  lamp_state_e nxt_state,
    output lamp_state_e cur_state
);

    always_ff @(posedge clk) begin
        if (rst) cur_state <= ST_OFF;
        else     cur_state <= nxt_state;
    end

endmodule

// File: rtl/tl_lamp_decode.sv
module tl_lamp_decode
    import tail_light_pkg::*;
(
    input  lamp_state_e cur_state,
    output bank_t       left_bank,
    output bank_t       right_bank
);

    always_comb begin
        left_bank  = BANK_OFF;
        right_bank = BANK_OFF;
        unique case (cur_state)
            ST_OFF:    ;
            ST_LEFT1:  left_bank  = fill_bank(1);
            ST_LEFT2:  left_bank  = fill_bank(2);
            ST_LEFT3:  left_bank  = fill_bank(3);
            ST_RIGHT1: right_bank = fill_bank(1);
            ST_RIGHT2: right_bank = fill_bank(2);
            ST_RIGHT3: right_bank = fill_bank(3);
            ST_ALL: begin
                left_bank  = BANK_ON;
                right_bank = BANK_ON;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tail_light_seq.sv
module tail_light_seq
    import tail_light_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  left_req,
    input  logic                  right_req,
    input  logic                  hazard_req,
    output logic [SIDE_LAMPS-1:0] left_lamp,
    output logic [SIDE_LAMPS-1:0] right_lamp
);

    lamp_state_e state_q;
    lamp_state_e state_d;

    tl_next_state u_next (
        .cur_state  (state_q),
        .left_req   (left_req),
        .right_req  (right_req),
        .hazard_req (hazard_req),
        .nxt_state  (state_d)
    );

    tl_state_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .nxt_state (state_d),
        .cur_state (state_q)
    );

    tl_lamp_decode u_dec (
        .cur_state  (state_q),
        .left_bank  (left_lamp),
        .right_bank (right_lamp)
    );

endmodule

// File: rtl/tail_light_seq_chk.sv
module tail_light_seq_chk
    import tail_light_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  left_req,
    input logic                  right_req,
    input logic                  hazard_req,
    input logic [SIDE_LAMPS-1:0] left_lamp,
    input logic [SIDE_LAMPS-1:0] right_lamp
);

    logic lamps_dark, lamps_all;
    assign lamps_dark = (left_lamp == BANK_OFF) && (right_lamp == BANK_OFF);
    assign lamps_all  = (left_lamp == BANK_ON)  && (right_lamp == BANK_ON);

    p_reset_dark_r1: assert property (@(posedge clk)
        rst |=> lamps_dark);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (lamps_dark && !left_req && !right_req && !hazard_req) |=> lamps_dark);

    p_left_start_r3: assert property (@(posedge clk) disable iff (rst)
        (lamps_dark && left_req && !right_req && !hazard_req)
        |=> (left_lamp == fill_bank(1) && right_lamp == BANK_OFF));

    p_right_start_r4: assert property (@(posedge clk) disable iff (rst)
        (lamps_dark && right_req && !left_req && !hazard_req)
        |=> (right_lamp == fill_bank(1) && left_lamp == BANK_OFF));

    p_all_start_r5: assert property (@(posedge clk) disable iff (rst)
        (lamps_dark && (hazard_req || (left_req && right_req))) |=> lamps_all);

    p_hazard_preempt_r6: assert property (@(posedge clk) disable iff (rst)
        (!lamps_dark && !lamps_all && hazard_req) |=> lamps_all);

    p_left_step_r7: assert property (@(posedge clk) disable iff (rst)
        (left_lamp == fill_bank(1) && right_lamp == BANK_OFF && !hazard_req)
        |=> (left_lamp == fill_bank(2)));

    p_one_bank_r8: assert property (@(posedge clk) disable iff (rst)
        (left_lamp == BANK_OFF) || (right_lamp == BANK_OFF) || lamps_all);

    p_all_then_dark_r9: assert property (@(posedge clk) disable iff (rst)
        lamps_all |=> lamps_dark);

endmodule

bind tail_light_seq tail_light_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .left_req   (left_req),
    .right_req  (right_req),
    .hazard_req (hazard_req),
    .left_lamp  (left_lamp),
    .right_lamp (right_lamp)
);

// File: tb/tail_light_seq_tb_top.sv
module tail_light_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       left_req = 1'b0, right_req = 1'b0, hazard_req = 1'b0;
    logic [2:0] left_lamp, right_lamp;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Model: mode 0 dark, 1 left, 2 right, 3 all-on; step = lamps lit.
    int mode = 0;
    int step = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tail_light_seq dut_i (
        .clk        (clk),
        .rst        (rst),
        .left_req   (left_req),
        .right_req  (right_req),
        .hazard_req (hazard_req),
        .left_lamp  (left_lamp),
        .right_lamp (right_lamp)
    );

    function automatic logic [2:0] lit(input int n);
        return 3'((1 << n) - 1);
    endfunction

    task automatic model_step(input bit r, input bit l, input bit rr, input bit h);
        if (r) begin
            mode = 0; step = 0;
        end else if (mode == 0) begin
            if (h || (l && rr)) mode = 3;
            else if (l)  begin mode = 1; step = 1; end
            else if (rr) begin mode = 2; step = 1; end
        end else if (mode == 3) begin
            mode = 0;
        end else if (h) begin
            mode = 3;
        end else if (step == 3) begin
            mode = 0; step = 0;
        end else begin
            step = step + 1;
        end
    endtask

    task automatic compare(input string tag);
        logic [2:0] exp_l, exp_r;
        exp_l = (mode == 1) ? lit(step) : (mode == 3) ? 3'b111 : 3'b000;
        exp_r = (mode == 2) ? lit(step) : (mode == 3) ? 3'b111 : 3'b000;
        compared++;
        if (left_lamp !== exp_l || right_lamp !== exp_r) begin
            mismatched++;
            $display("FAIL %s cycle %0d: lamps L=%b R=%b expected L=%b R=%b",
                     tag, cycles, left_lamp, right_lamp, exp_l, exp_r);
        end
        // R8: at most one partly lit bank
        compared++;
        if (left_lamp != 3'b000 && right_lamp != 3'b000 &&
            !(left_lamp == 3'b111 && right_lamp == 3'b111)) begin
            mismatched++;
            $display("FAIL R8 cycle %0d: L=%b R=%b expected one bank dark",
                     cycles, left_lamp, right_lamp);
        end
    endtask

    // Drive one cycle's inputs, let the edge pass, check at the falling edge.
    task automatic cyc(input bit r, input bit l, input bit rr, input bit h,
                       input string tag);
        rst = r; left_req = l; right_req = rr; hazard_req = h;
        @(posedge clk);
        model_step(r, l, rr, h);
        @(negedge clk);
        compare(tag);
    endtask

    always @(posedge clk) cycles++;

    initial begin
        @(negedge clk);
        cyc(1, 0, 0, 0, "R1");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R2");

        // R3: single left pulse, then three steps and back to dark
        cyc(0, 1, 0, 0, "R3");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R3");
        // left held: sequence repeats
        for (int i = 0; i < 9; i++) cyc(0, 1, 0, 0, "R3");
        cyc(0, 0, 0, 0, "R3");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R3");

        // R4: right pulse and held
        cyc(0, 0, 1, 0, "R4");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R4");
        for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, "R4");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R4");

        // R5: hazard from dark, then left+right together
        cyc(0, 0, 0, 1, "R5");
        cyc(0, 0, 0, 0, "R5");
        cyc(0, 1, 1, 0, "R5");
        cyc(0, 1, 1, 0, "R9");
        cyc(0, 0, 0, 0, "R5");

        // R9: held hazard alternates; also held with turn requests
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, "R9");
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 1, "R9");
        cyc(0, 0, 0, 0, "R9");
        cyc(0, 0, 0, 0, "R9");

        // R6: hazard at each step of a left and a right sequence
        for (int s = 1; s <= 3; s++) begin
            cyc(0, 1, 0, 0, "R6");
            for (int k = 1; k < s; k++) cyc(0, 0, 0, 0, "R6");
            cyc(0, 0, 0, 1, "R6");
            cyc(0, 0, 0, 0, "R6");
            cyc(0, 0, 0, 0, "R6");
        end
        for (int s = 1; s <= 3; s++) begin
            cyc(0, 0, 1, 0, "R6");
            for (int k = 1; k < s; k++) cyc(0, 0, 0, 0, "R6");
            cyc(0, 0, 1, 1, "R6");
            cyc(0, 0, 0, 0, "R6");
            cyc(0, 0, 0, 0, "R6");
        end

        // R7: opposite-side and dual requests during a running sequence
        cyc(0, 1, 0, 0, "R7");
        cyc(0, 0, 1, 0, "R7");
        cyc(0, 1, 1, 0, "R7");
        cyc(0, 0, 1, 0, "R7");
        cyc(0, 0, 1, 0, "R7");
        cyc(0, 0, 0, 0, "R7");
        cyc(0, 0, 1, 0, "R7");
        cyc(0, 1, 0, 0, "R7");
        cyc(0, 1, 0, 0, "R7");
        cyc(0, 0, 0, 0, "R7");
        cyc(0, 0, 0, 0, "R7");

        // R1: reset in the middle of a sequence and during all-on
        cyc(0, 1, 0, 0, "R1");
        cyc(0, 0, 0, 0, "R1");
        cyc(1, 1, 0, 1, "R1");
        cyc(0, 0, 0, 1, "R1");
        cyc(1, 0, 0, 0, "R1");
        cyc(0, 0, 0, 0, "R2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule